// File: doc/BRIEF.md
# Dual-Mode Serial Result Transmitter

This block shifts a converter result word out on one serial data line, most significant bit first. A mode pin selects the clocking scheme. In internal mode the block makes its own data clock: every convert command, which is a falling edge of the OR of chip select and read/convert, sends the previously held result with exactly `W` clock pulses. In external mode a host supplies the data clock. A read trigger produces a one-period framing pulse, then the result bits, then the tag input delayed by twelve data clocks, so that several parts can be daisy-chained on one line.

The held result is reloaded when BUSY rises, which marks the end of a conversion. A read made while a conversion is still running therefore sends the older word, and a read made after BUSY has risen sends the newer one. A format pin chooses the output coding. The incoming word is treated as straight binary, and two's complement coding is produced by inverting its top bit. The generated clock timing is set in system clock cycles. The external data clock is synchronised to the system clock.

Top module: `serial_result_tx`

## Requirements
- R1: After reset, `data`, `sync` and `dclk_out` are all low.
- R2: In internal mode (`ext_mode` low), a falling edge of (`cs_n` OR `rd_conv`) starts a transfer that produces exactly `W` high pulses on `dclk_out`. After the last pulse, `dclk_out` stays low until the next convert command.
- R3: In internal mode, the first `dclk_out` rise comes `START_DLY + HALF` system cycles after the clock edge that sees the convert command. Rises are `2*HALF` cycles apart, and each high phase lasts `HALF-1` cycles.
- R4: In internal mode, bits go out MSB first. `data` does not change at any rising or falling edge of `dclk_out`.
- R5: In internal mode, outside the shifting window, `data` shows the `tag` level sampled at the most recent convert command (low after reset).
- R6: In external mode, a transfer is triggered by a rise of `rd_conv` while `cs_n` is low, or by a fall of `cs_n` while `rd_conv` is high. `sync` goes high at the first rising edge of `ext_dclk` after the trigger and falls at the next one.
- R7: In external mode, the window after the k-th `ext_dclk` rise following the framing rise (k = 1..`W`) carries result bit `W-k`.
- R8: In external mode, the window after framing-rise-relative edge k > `W` carries the `tag` level sampled at edge k-12. When `cs_n` goes high or `rd_conv` goes low, the transfer ends: `data` and `sync` go low within two cycles.
- R9: The held result is loaded from `result_in` when `busy` rises. A transfer sends the held word as it stands at the trigger. If `busy` rises in the same cycle as the trigger, the new `result_in` is sent.
- R10: With `fmt_sb` high the word is sent unchanged (straight binary). With it low, bit `W-1` is inverted (two's complement). The format is sampled at the trigger.
- R11: In external mode, a convert command produces no `dclk_out` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| result_in | input | W | Latest conversion result, straight binary |
| busy | input | 1 | Low while converting; its rise marks a new result |
| cs_n | input | 1 | Active-low chip select |
| rd_conv | input | 1 | Read/convert control |
| tag | input | 1 | Daisy-chain input |
| fmt_sb | input | 1 | 1 = straight binary, 0 = two's complement |
| ext_mode | input | 1 | 1 = host data clock, 0 = generated clock |
| ext_dclk | input | 1 | Host data clock (external mode) |
| data | output | 1 | Serial data line |
| sync | output | 1 | Framing pulse (external mode) |
| dclk_out | output | 1 | Generated data clock (internal mode) |

## Verification
The critical overlap is a read trigger landing in the same system cycle as the rise of `busy` that reloads the held result. The bench provokes it by driving the `cs_n` fall and the `busy` rise on the same clock edge, with `rd_conv` held high. It judges the outcome by comparing the serial bits after the framing pulse against the new `result_in` rather than the stale held word. The two other orderings, a read during the conversion and a read after it, are also run, and each must return its own conversion.

// File: rtl/serial_result_tx.sv
module serial_result_tx #(
  parameter int W         = 12,
  parameter int START_DLY = 22,
  parameter int HALF      = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] result_in,
  input  logic         busy,
  input  logic         cs_n,
  input  logic         rd_conv,
  input  logic         tag,
  input  logic         fmt_sb,
  input  logic         ext_mode,
  input  logic         ext_dclk,
  output logic         data,
  output logic         sync,
  output logic         dclk_out
);
  localparam int TMAX = (START_DLY > 2*HALF) ? START_DLY : 2*HALF;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(W + 1);

  typedef enum logic [2:0] {IDLE, I_WAIT, I_SHIFT, X_ARM, X_SYNC, X_SHIFT} st_t;
  st_t st;

  logic          cs_q, rc_q, busy_q, ds1, ds2, ds3, tag_hold, tag_d;
  logic [W-1:0]  held, sh;
  logic [TW-1:0] tmr;
  logic [BW-1:0] bitcnt;

  wire           or_fall   = (cs_q | rc_q) & ~(cs_n | rd_conv);
  wire           rd_hold   = ~cs_n & rd_conv;
  wire           x_trig    = rd_hold & (~rc_q | cs_q);
  wire           busy_rise = busy & ~busy_q;
  wire           dclk_rise = ds2 & ~ds3;
  wire [W-1:0]   cur_word  = busy_rise ? result_in : held;
  wire [W-1:0]   fmt_word  = fmt_sb ? cur_word : {~cur_word[W-1], cur_word[W-2:0]};

  assign dclk_out = (st == I_SHIFT) && (tmr >= TW'(HALF)) && (tmr < TW'(2*HALF-1));
  assign sync     = (st == X_SYNC);
  assign data     = (st == I_SHIFT || st == X_SHIFT) ? sh[W-1] : (~ext_mode & tag_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1; rc_q <= 1'b1; busy_q <= 1'b1;
      ds1 <= 1'b0; ds2 <= 1'b0; ds3 <= 1'b0;
      held <= '0;
    end else begin
      cs_q <= cs_n; rc_q <= rd_conv; busy_q <= busy;
      ds1 <= ext_dclk; ds2 <= ds1; ds3 <= ds2;
      if (busy_rise) held <= result_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; sh <= '0; tmr <= '0; bitcnt <= '0;
      tag_hold <= 1'b0; tag_d <= 1'b0;
    end else begin
      if (dclk_rise) tag_d <= tag;
      case (st)
        IDLE:
          if (!ext_mode && or_fall) begin
            st <= I_WAIT; tmr <= '0; sh <= fmt_word; tag_hold <= tag;
          end else if (ext_mode && x_trig) begin
            st <= X_ARM; sh <= fmt_word;
          end
        I_WAIT:
          if (tmr == TW'(START_DLY-1)) begin
            st <= I_SHIFT; tmr <= '0; bitcnt <= '0;
          end else tmr <= tmr + 1'b1;
        I_SHIFT:
          if (tmr == TW'(2*HALF-1)) begin
            tmr <= '0;
            if (bitcnt == BW'(W-1)) st <= IDLE;
            else begin
              bitcnt <= bitcnt + 1'b1;
              sh <= {sh[W-2:0], 1'b0};
            end
          end else tmr <= tmr + 1'b1;
        X_ARM:
          if (!rd_hold) st <= IDLE;
          else if (dclk_rise) st <= X_SYNC;
        X_SYNC:
          if (!rd_hold) st <= IDLE;
          else if (dclk_rise) st <= X_SHIFT;
        X_SHIFT:
          if (!rd_hold) st <= IDLE;
          else if (dclk_rise) sh <= {sh[W-2:0], tag_d};
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == I_SHIFT) |-> (bitcnt < BW'(W)));
  // R4
  data_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk_out) |-> $stable(data));
  // R4
  data_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_out) |-> $stable(data));
  // R6
  sync_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync) |-> ($past(dclk_rise) || !$past(rd_hold)));
  // R11
  ext_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_out) |-> !ext_mode);
  // R9
  held_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rise |=> (held == $past(result_in)));
endmodule

// File: tb/serial_result_tx_test.sv
module serial_result_tx_test;
  localparam int W = 12, SD = 22, H = 11;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_conv = 1, busy = 1, tag = 0;
  logic fmt_sb = 1, ext_mode = 0, ext_dclk = 0;
  logic [W-1:0] result_in = '0;
  wire data, sync, dclk_out;

  serial_result_tx #(.W(W), .START_DLY(SD), .HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .result_in(result_in), .busy(busy), .cs_n(cs_n),
    .rd_conv(rd_conv), .tag(tag), .fmt_sb(fmt_sb), .ext_mode(ext_mode),
    .ext_dclk(ext_dclk), .data(data), .sync(sync), .dclk_out(dclk_out));

  always #10 clk = ~clk;

  typedef struct { logic d; logic s; string req; } exp_t;
  exp_t iq[$], xq[$];
  exp_t ie, xe;
  int errs = 0, checks = 0;
  int pulses = 0, cyc = 0, last_rise = -1;
  logic prev_dclk = 0, rise_data = 0;
  event smp_ev;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (dclk_out && !prev_dclk) begin
      pulses++;
      if (iq.size() == 0) chk(0, "R2 extra pulse", pulses, 0);
      else begin
        ie = iq.pop_front();
        chk(data === ie.d, ie.req, data, ie.d);
      end
      if (last_rise >= 0) chk(cyc - last_rise == 2*H, "R3 period", cyc - last_rise, 2*H);
      last_rise = cyc;
      rise_data = data;
    end
    if (!dclk_out && prev_dclk) begin
      chk(data === rise_data, "R4 stable at fall", data, rise_data);
      chk(cyc - last_rise == H - 1, "R3 high width", cyc - last_rise, H - 1);
    end
    prev_dclk = dclk_out;
  end

  always @(smp_ev) begin
    xe = xq.pop_front();
    chk(data === xe.d, xe.req, data, xe.d);
    chk(sync === xe.s, "R6 sync level", sync, xe.s);
  end

  task automatic int_conv(input logic [W-1:0] word, input logic tv);
    int n = 0;
    logic [W-1:0] ew = fmt_sb ? word : word ^ (1 << (W-1));
    pulses = 0; last_rise = -1;
    for (int i = W-1; i >= 0; i--) iq.push_back('{ew[i], 1'b0, "R4 bit"});
    @(negedge clk); cs_n = 0; tag = tv;
    @(negedge clk); rd_conv = 0; busy = 0;
    while (!dclk_out && n < 200) begin @(negedge clk); n++; if (n == 2) tag = ~tv; end
    chk(n == SD + H + 1, "R3 start delay", n, SD + H + 1);
    repeat (W*2*H + 4) @(negedge clk);
    chk(pulses == W, "R2 pulse count", pulses, W);
    chk(dclk_out == 0, "R2 clock low after", dclk_out, 0);
    chk(data === tv, "R5 idle tag level", data, tv);
    rd_conv = 1; cs_n = 1;
  endtask

  task automatic ext_read(input int kind, input logic [W-1:0] word, input int nr);
    logic tv[64];
    logic [W-1:0] ew = fmt_sb ? word : word ^ (1 << (W-1));
    pulses = 0;
    @(negedge clk);
    if (kind == 0) begin
      cs_n = 0; rd_conv = 0;
      repeat (3) @(negedge clk);
      rd_conv = 1;
    end else if (kind == 1) cs_n = 0;
    else begin cs_n = 0; busy = 1; end
    repeat (3) @(negedge clk);
    for (int j = 0; j < nr; j++) begin
      tv[j] = ((j * 7) >> 1) & 1;
      tag = tv[j]; ext_dclk = 1;
      repeat (4) @(negedge clk);
      ext_dclk = 0;
      repeat (3) @(negedge clk);
      if (j == 0) xq.push_back('{1'b0, 1'b1, "R6 framing"});
      else if (j <= W) xq.push_back('{ew[W-j], 1'b0, (j == 1) ? "R7 msb" : "R7 bit"});
      else xq.push_back('{tv[j-12], 1'b0, "R8 tag delay"});
      -> smp_ev;
      @(negedge clk);
    end
    cs_n = 1;
    repeat (2) @(negedge clk);
    chk(data == 0 && sync == 0, "R8 end of read", {data, sync}, 0);
    chk(pulses == 0, "R11 no generated clock", pulses, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(data == 0 && sync == 0 && dclk_out == 0, "R1 reset outputs", {data, sync, dclk_out}, 0);
    rst_n = 1;
    @(negedge clk); busy = 0; result_in = 12'h5A3;
    @(negedge clk); busy = 1;
    @(negedge clk);
    int_conv(12'h5A3, 1'b1);
    fmt_sb = 0;
    int_conv(12'h5A3, 1'b0);       // R10 two's complement
    fmt_sb = 1; result_in = 12'h7FF;
    int_conv(12'h5A3, 1'b1);       // R9 held word during conversion
    @(negedge clk); result_in = 12'h0F0; busy = 1;
    @(negedge clk);
    ext_mode = 1;
    ext_read(1, 12'h0F0, 18);      // R9 read after busy rose
    @(negedge clk); busy = 0; result_in = 12'hABC; fmt_sb = 0;
    ext_read(0, 12'h0F0, 16);      // R9 read during conversion returns previous
    fmt_sb = 1;
    ext_read(2, 12'hABC, 14);      // R9 same-cycle busy rise and trigger
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule